// File: doc/BRIEF.md
# Folded Word Memory with Predecoded Row Select

This block is a synthesizable register model of a single-port memory holding 2048 words of 16 bits. The words are not stored one per row. They are folded into a bit array of 256 rows by 128 columns, so each row carries eight words interleaved bit by bit. A clock cycle performs one read, one write, or nothing.

The 11-bit address has two fields. The upper eight bits name a row. The lower three bits name a column inside each group of eight columns. The row field is split into two 4-bit halves. Each half is decoded into 16 one-hot lines. A final two-input AND per row combines one line from each half to raise that row's wordline. On the column side, sixteen 8:1 selectors take one column from each 8-column group of the active row. Word bit i lives in column 8*i + col.

A write changes only the 16 columns chosen inside the active row. A read places the selected word in an output register, which holds it until the next read.

Top module: `folded_sram`

## Requirements
- R1: While reset is high, rdata becomes zero on the next clock edge.
- R2: A read (ce=1, we=0) presents, right after the clock edge that accepts it, the word most recently written to that address. Back-to-back write-then-read of the same address is included.
- R3: A write changes only the addressed word. The other seven words that share its row (same addr[10:3], different addr[2:0]) keep their values.
- R4: With ce high, exactly one wordline is active. Its index equals addr[10:3]. It is formed as high-group line addr[10:7] ANDed with low-group line addr[6:3]. Words in different rows with the same addr[2:0] are therefore independent.
- R5: With ce low, no wordline is active and the array is not written, even when we is high.
- R6: In a write cycle (ce=1, we=1), rdata keeps its previous value.
- R7: In a cycle with ce low, rdata keeps its previous value.
- R8: The lowest address (0) and the highest address (2047) store and return data like any other address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | Clock; all state changes on the rising edge |
| rst | input | 1 | Synchronous active-high reset of the read register |
| ce | input | 1 | Access enable; low means no access this cycle |
| we | input | 1 | 1 = write, 0 = read, when ce is high |
| addr | input | 11 | Word address: [10:3] row, [2:0] column within each group |
| wdata | input | 16 | Word to store on a write |
| rdata | output | 16 | Registered read word, updated only by reads |

## Verification
The checker looks at the decoder on every cycle. With ce high it requires a single active wordline at the addressed row. With ce low it requires no active wordline. It also checks that rdata holds through write cycles and disabled cycles, and that it clears after reset. Correct storage can only be shown by the bench's scenarios: the readback value, the isolation of the seven neighbours in a row, the independence of one column across all 256 rows, a blocked write while ce is low, and the two extreme addresses. A scoreboard compares each read against a bench-side word model.

// File: rtl/fsr_pkg.sv
package fsr_pkg;

    localparam int ADDR_W    = 11;
    localparam int WORD_W    = 16;
    localparam int COL_SEL_W = 3;
    localparam int ROW_W     = ADDR_W - COL_SEL_W;
    localparam int ROWS      = 1 << ROW_W;
    localparam int COL_GROUP = 1 << COL_SEL_W;
    localparam int COLS      = WORD_W * COL_GROUP;
    localparam int PRE_HI_W  = ROW_W / 2;
    localparam int PRE_LO_W  = ROW_W - PRE_HI_W;
    localparam int PRE_HI_N  = 1 << PRE_HI_W;
    localparam int PRE_LO_N  = 1 << PRE_LO_W;

    // Row field sits above the column field, matching addr[10:3] / addr[2:0].
    typedef struct packed {
        logic [ROW_W-1:0]     row;
        logic [COL_SEL_W-1:0] col;
    } addr_t;

    typedef struct packed {
        logic [PRE_HI_W-1:0] hi;
        logic [PRE_LO_W-1:0] lo;
    } row_split_t;

    typedef enum logic [1:0] {
        ACC_IDLE  = 2'd0,
        ACC_READ  = 2'd1,
        ACC_WRITE = 2'd2
    } acc_e;

    function automatic acc_e classify(input logic ce, input logic we);
        if (!ce)
            return ACC_IDLE;
        else if (we)
            return ACC_WRITE;
        else
            return ACC_READ;
    endfunction

    function automatic row_split_t split_row(input logic [ROW_W-1:0] row);
        return row_split_t'(row);
    endfunction

endpackage

// File: rtl/fsr_predecode.sv
module fsr_predecode #(
    parameter int IN_W = 4,
    localparam int OUT_N = 1 << IN_W
) (
    input  logic [IN_W-1:0]  sel,
    input  logic             en,
    output logic [OUT_N-1:0] line
);

    for (genvar j = 0; j < OUT_N; j++) begin : g_line
        assign line[j] = en && (sel == IN_W'(j));
    end

endmodule

// File: rtl/fsr_row_and.sv
module fsr_row_and #(
    parameter int HI_N = 16,
    parameter int LO_N = 16,
    localparam int ROW_N = HI_N * LO_N
) (
    input  logic [HI_N-1:0]  hi_line,
    input  logic [LO_N-1:0]  lo_line,
    output logic [ROW_N-1:0] wordline
);

    // One two-input AND per row: one term from each predecoded group.
    for (genvar r = 0; r < ROW_N; r++) begin : g_row
        assign wordline[r] = hi_line[r / LO_N] & lo_line[r % LO_N];
    end

endmodule

// File: rtl/fsr_col_map.sv
module fsr_col_map #(
    parameter int WORD_W = 16,
    parameter int SEL_W  = 3,
    localparam int GROUP = 1 << SEL_W,
    localparam int COLS  = WORD_W * GROUP
) (
    input  logic [SEL_W-1:0]  col,
    input  logic [WORD_W-1:0] wdata,
    input  logic [COLS-1:0]   row_bits,
    output logic [COLS-1:0]   col_mask,
    output logic [COLS-1:0]   wide_data,
    output logic [WORD_W-1:0] word_out
);

    // Word bit i occupies column GROUP*i + col.
    for (genvar i = 0; i < WORD_W; i++) begin : g_bit
        logic [GROUP-1:0] grp_bits;
        assign grp_bits    = row_bits[GROUP*i +: GROUP];
        assign word_out[i] = grp_bits[col];
        for (genvar g = 0; g < GROUP; g++) begin : g_col
            assign col_mask[GROUP*i + g]  = (col == SEL_W'(g));
            assign wide_data[GROUP*i + g] = wdata[i];
        end
    end

endmodule

// File: rtl/fsr_bit_array.sv
module fsr_bit_array #(
    parameter int ROWS = 256,
    parameter int COLS = 128
) (
    input  logic            clk,
    input  logic [ROWS-1:0] wordline,
    input  logic            wr_en,
    input  logic [COLS-1:0] col_mask,
    input  logic [COLS-1:0] wide_data,
    output logic [COLS-1:0] row_out
);

    logic [COLS-1:0] cells [ROWS];

    always_ff @(posedge clk) begin
        for (int r = 0; r < ROWS; r++) begin
            if (wr_en && wordline[r])
                cells[r] <= (cells[r] & ~col_mask) | (wide_data & col_mask);
        end
    end

    // Wordline-gated AND-OR read of the active row.
    always_comb begin
        row_out = '0;
        for (int r = 0; r < ROWS; r++)
            row_out = row_out | (cells[r] & {COLS{wordline[r]}});
    end

endmodule

// File: rtl/folded_sram.sv
module folded_sram
    import fsr_pkg::*;
(
    input  logic              clk,
    input  logic              rst,
    input  logic              ce,
    input  logic              we,
    input  logic [ADDR_W-1:0] addr,
    input  logic [WORD_W-1:0] wdata,
    output logic [WORD_W-1:0] rdata
);

    addr_t              a;
    row_split_t         rs;
    acc_e               kind;
    logic [PRE_HI_N-1:0] hi_line;
    logic [PRE_LO_N-1:0] lo_line;
    logic [ROWS-1:0]    wordline;
    logic [COLS-1:0]    col_mask;
    logic [COLS-1:0]    wide_data;
    logic [COLS-1:0]    row_out;
    logic [WORD_W-1:0]  word_sel;
    logic [WORD_W-1:0]  rdata_q;

    assign a    = addr_t'(addr);
    assign rs   = split_row(a.row);
    assign kind = classify(ce, we);

    fsr_predecode #(.IN_W(PRE_HI_W)) u_pre_hi (
        .sel  (rs.hi),
        .en   (ce),
        .line (hi_line)
    );

    fsr_predecode #(.IN_W(PRE_LO_W)) u_pre_lo (
        .sel  (rs.lo),
        .en   (ce),
        .line (lo_line)
    );

    fsr_row_and #(.HI_N(PRE_HI_N), .LO_N(PRE_LO_N)) u_row_and (
        .hi_line  (hi_line),
        .lo_line  (lo_line),
        .wordline (wordline)
    );

    fsr_col_map #(.WORD_W(WORD_W), .SEL_W(COL_SEL_W)) u_col_map (
        .col       (a.col),
        .wdata     (wdata),
        .row_bits  (row_out),
        .col_mask  (col_mask),
        .wide_data (wide_data),
        .word_out  (word_sel)
    );

    fsr_bit_array #(.ROWS(ROWS), .COLS(COLS)) u_array (
        .clk       (clk),
        .wordline  (wordline),
        .wr_en     (kind == ACC_WRITE),
        .col_mask  (col_mask),
        .wide_data (wide_data),
        .row_out   (row_out)
    );

    always_ff @(posedge clk) begin
        if (rst)
            rdata_q <= '0;
        else if (kind == ACC_READ)
            rdata_q <= word_sel;
    end

    assign rdata = rdata_q;

endmodule

// File: rtl/fsr_checker.sv
module fsr_checker
    import fsr_pkg::*;
(
    input logic              clk,
    input logic              rst,
    input logic              ce,
    input logic              we,
    input logic [ADDR_W-1:0] addr,
    input logic [WORD_W-1:0] rdata,
    input logic [ROWS-1:0]   wordline
);

    addr_t ca;
    assign ca = addr_t'(addr);

    AST_RST_ZERO: assert property (@(posedge clk)
        rst |=> (rdata == '0));  // R1

    AST_WL_SINGLE: assert property (@(posedge clk) disable iff (rst)
        ce |-> ($countones(wordline) == 1));  // R4

    AST_WL_ROW: assert property (@(posedge clk) disable iff (rst)
        ce |-> wordline[ca.row]);  // R4

    AST_WL_NONE: assert property (@(posedge clk) disable iff (rst)
        !ce |-> (wordline == '0));  // R5

    AST_HOLD_WRITE: assert property (@(posedge clk) disable iff (rst)
        (ce && we) |=> $stable(rdata));  // R6

    AST_HOLD_OFF: assert property (@(posedge clk) disable iff (rst)
        !ce |=> $stable(rdata));  // R7

endmodule

bind folded_sram fsr_checker u_fsr_checker (
    .clk      (clk),
    .rst      (rst),
    .ce       (ce),
    .we       (we),
    .addr     (addr),
    .rdata    (rdata),
    .wordline (wordline)
);

// File: tb/folded_sram_tb_top.sv
module folded_sram_tb_top;

    logic        clk = 1'b0;
    logic        rst = 1'b1;
    logic        ce  = 1'b0;
    logic        we  = 1'b0;
    logic [10:0] addr  = '0;
    logic [15:0] wdata = '0;
    logic [15:0] rdata;

    int checks   = 0;
    int failures = 0;

    logic [15:0] model [2048];
    logic [15:0] exp_q [$];
    string       tag_q [$];
    string       cur_tag = "R7";
    logic [15:0] last_rd = '0;
    bit          hold_armed = 0;
    bit          done = 0;

    always #10 clk = ~clk;

    folded_sram dut_i (
        .clk   (clk),
        .rst   (rst),
        .ce    (ce),
        .we    (we),
        .addr  (addr),
        .wdata (wdata),
        .rdata (rdata)
    );

    task automatic check(input bit ok, input string tag,
                         input logic [15:0] act, input logic [15:0] exp);
        checks++;
        if (!ok) begin
            failures++;
            $display("FAIL %s actual=%h expected=%h", tag, act, exp);
        end
    endtask

    task automatic wr(input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        ce = 1'b1; we = 1'b1; addr = a; wdata = d; cur_tag = "R6";
        model[a] = d;
    endtask

    task automatic rd(input logic [10:0] a, input string tag);
        @(negedge clk);
        ce = 1'b1; we = 1'b0; addr = a; cur_tag = tag;
        exp_q.push_back(model[a]);
        tag_q.push_back(tag);
    endtask

    task automatic idle(input logic w, input logic [10:0] a, input logic [15:0] d);
        @(negedge clk);
        ce = 1'b0; we = w; addr = a; wdata = d; cur_tag = "R7";
    endtask

    // Monitor: pops expected read words, checks hold on other cycles.
    always begin
        bit    k_read;
        bit    k_hold;
        string t;
        logic [15:0] e;
        @(posedge clk);
        k_read = !rst && ce && !we;
        k_hold = !rst && !(ce && !we);
        t = cur_tag;
        #2;
        if (k_read) begin
            if (exp_q.size() == 0) begin
                check(1'b0, "scoreboard-underflow", rdata, 16'h0);
            end else begin
                e = exp_q.pop_front();
                t = tag_q.pop_front();
                check(rdata === e, t, rdata, e);
            end
        end else if (k_hold && hold_armed) begin
            check(rdata === last_rd, t, rdata, last_rd);
        end
        last_rd = rdata;
        hold_armed = !rst;
    end

    initial begin
        #(20 * 200000);
        checks++;
        failures++;
        $display("FAIL watchdog actual=timeout expected=completion");
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        check(rdata === 16'h0, "R1", rdata, 16'h0);

        // R8: extreme addresses
        wr(11'd0, 16'hA5A5);
        wr(11'd2047, 16'h5A5A);
        rd(11'd0, "R8");
        rd(11'd2047, "R8");

        // R3: all eight words of one row, then overwrite one
        for (int c = 0; c < 8; c++) wr(11'(5*8 + c), 16'(16'h1000 + c*16'h0111));
        for (int c = 0; c < 8; c++) rd(11'(5*8 + c), "R3");
        wr(11'(5*8 + 3), 16'hFFFF);
        for (int c = 0; c < 8; c++) rd(11'(5*8 + c), "R3");
        wr(11'(5*8 + 6), 16'h0000);
        for (int c = 0; c < 8; c++) rd(11'(5*8 + c), "R3");

        // R4: same column in every row, distinct data per row
        for (int r = 0; r < 256; r++) wr(11'(r*8 + 6), 16'(r*257) ^ 16'h3C3C);
        for (int r = 0; r < 256; r++) rd(11'(r*8 + 6), "R4");

        // R2: write immediately followed by read, walking ones
        for (int b = 0; b < 16; b++) begin
            wr(11'(700 + b), 16'(1) << b);
            rd(11'(700 + b), "R2");
        end
        rd(11'd705, "R2");
        rd(11'd706, "R2");

        // R6: read, then writes elsewhere; hold checked by monitor
        rd(11'd0, "R2");
        wr(11'd1500, 16'hBEEF);
        wr(11'd1501, 16'hCAFE);
        rd(11'd1500, "R2");

        // R5 / R7: disabled cycles with we high do not write
        idle(1'b1, 11'd0, 16'hDEAD);
        idle(1'b1, 11'd2047, 16'hDEAD);
        idle(1'b0, 11'd1501, 16'h1234);
        rd(11'd0, "R5");
        rd(11'd2047, "R5");
        rd(11'd1501, "R5");

        idle(1'b0, 11'd0, 16'h0);
        idle(1'b0, 11'd0, 16'h0);
        @(negedge clk);
        if (exp_q.size() != 0)
            check(1'b0, "scoreboard-leftover", 16'(exp_q.size()), 16'h0);
        $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
        $finish;
    end

endmodule